// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot-level hot-plug registers of a single-slot express port. Software reaches three word locations over a plain read/write bus: a control word, a status word and a read-only link capability word. The control word drives two indicator outputs (attention and power) and the slot power request. It also holds one enable per event and a global interrupt enable. The status word collects five events as sticky bits that software clears by writing 1: attention button pressed, power fault, latch sensor changed, presence changed and command completed.

Every write to the control word starts a completion timer. When the timer expires, the block posts the command-completed event, so software can pace its writes. The power-fault event is held while the slot is unpowered, so a fault seen on a dead slot survives any attempt to clear it. The single interrupt output is raised whenever an enabled event is pending and the global enable is set. The slot power output follows the power-controller bit after a fixed delay.

The bus has no back-pressure. A write is accepted in the cycle `bus_wr` is high. A read is accepted in the cycle `bus_rd` is high, and its data appears one cycle later, qualified by `bus_rvalid`. A master must therefore be ready to take read data in that cycle.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, the control word reads 0x07C0 (both indicators 11 = off, power-controller bit = 1 = off, all enables 0). The status word reads 0x0000. `irq` and `slot_power` are 0, and `attn_led` and `pwr_led` are both 3.
- R2: A write to address 0 stores bits 10:0 of the data, and bits 15:11 read back as 0. `attn_led` follows bits 7:6 and `pwr_led` follows bits 9:8 (01 on, 10 blink, 11 off) from the cycle after the write.
- R3: A read at address 0 returns the control word, 1 the status word, 2 the link capability word and 3 returns zero. Data and `bus_rvalid` appear the cycle after `bus_rd`. The link capability word is {6'b0, LINK_WIDTH (bits 9:4), LINK_SPEED (bits 3:0)}, 0x0011 by default, and writes to it are ignored.
- R4: Every control write, including one that only changes enables, sets status bit 4 (command completed) CMD_DELAY cycles after the write edge (default 4). A new control write inside that window restarts the count.
- R5: Writing 1 to a status bit in 4:0 clears it, and writing 0 leaves it unchanged. Writing 0x1F clears every bit whose cause is no longer active.
- R6: Status bit 1 (power fault) is set in every cycle the synchronised fault input is high. While `slot_power` is 0, a write of 1 to bit 1 is ignored. While powered, the write clears the bit unless the fault input is still high.
- R7: Status bit 2 is set on either edge of the synchronised latch input, and bit 3 on either edge of the synchronised presence input. Status bits 5 and 6 read the present latch and presence levels.
- R8: Status bit 0 is set on the rising edge of the debounced button. A button pulse shorter than DEBOUNCE cycles is ignored, and a release sets nothing.
- R9: `irq` = control bit 5 AND the OR over i in 0..4 of (status bit i AND control bit i). It falls in the cycle after the write that clears the last enabled pending bit or that drops an enable.
- R10: Control bit 10 requests power off (1) or on (0). `slot_power` takes the requested state PWR_DELAY cycles after the write that changes the bit (default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 link capability |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| btn_in | input | 1 | Raw attention button, asynchronous |
| fault_in | input | 1 | Power fault level, asynchronous |
| latch_in | input | 1 | Retention latch sensor level, asynchronous |
| present_in | input | 1 | Card presence level, asynchronous |
| attn_led | output | 2 | Attention indicator state |
| pwr_led | output | 2 | Power indicator state |
| slot_power | output | 1 | Slot power enable |
| irq | output | 1 | Hot-plug interrupt |

## Verification
The bench times the completion event to the exact cycle. It then repeats a control write two cycles into the window. A timer that did not restart would raise the interrupt three cycles too early, and one with an off-by-one delay would be caught at either bound. Clearing the fault while unpowered, and again while the fault input is held high, catches a design that lets the clear win over the held or still-active fault. Short button pulses, falling latch and presence edges, and writes of 0 to the status word catch wrong edge polarity, a missing debounce and a status word that clears on any write.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int NUM_EV = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LCAP = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;

  // event bit positions, shared by status bits and their enables
  localparam int EV_BTN   = 0;
  localparam int EV_FAULT = 1;
  localparam int EV_LATCH = 2;
  localparam int EV_PRES  = 3;
  localparam int EV_CMD   = 4;

  localparam int C_GLOBAL_EN = 5;
  localparam int C_ATTN_LO   = 6;
  localparam int C_PIND_LO   = 8;
  localparam int C_PWR_OFF   = 10;

  localparam logic [DATA_W-1:0] CTRL_MASK = 16'h07FF;
  localparam logic [DATA_W-1:0] CTRL_RST  = 16'h07C0;
endpackage

// File: rtl/hp_in_sync.sv
module hp_in_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d[g]};
      end
      assign q[g] = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hp_debounce.sv
module hp_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  // the level must differ from the held value for CYCLES clocks in a row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_slot_pkg::*;
#(
  parameter int CMD_DELAY = 4,
  parameter int PWR_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              cmd_done,
  output logic              slot_power
);
  localparam int CCW = $clog2(CMD_DELAY + 1);
  localparam int PCW = $clog2(PWR_DELAY + 1);
  localparam logic [PCW-1:0] PWR_LAST = PCW'(PWR_DELAY - 1);

  logic [CCW-1:0] cmd_cnt;
  logic [PCW-1:0] pwr_cnt;
  logic           pwr_req;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= wdata & CTRL_MASK;
  end

  // completion timer: reloaded by every control write
  always_ff @(posedge clk) begin
    if (!rst_n)              cmd_cnt <= '0;
    else if (wr_en)          cmd_cnt <= CCW'(CMD_DELAY);
    else if (cmd_cnt != '0)  cmd_cnt <= cmd_cnt - 1'b1;
  end
  assign cmd_done = (cmd_cnt == CCW'(1)) && !wr_en;

  // power sequencer: output moves once the request has differed long enough
  assign pwr_req = !ctrl_q[C_PWR_OFF];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_power <= 1'b0;
      pwr_cnt    <= '0;
    end else if (pwr_req == slot_power) begin
      pwr_cnt <= '0;
    end else if (pwr_cnt == PWR_LAST) begin
      slot_power <= pwr_req;
      pwr_cnt    <= '0;
    end else begin
      pwr_cnt <= pwr_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hp_status_reg.sv
module hp_status_reg
  import hp_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_ev,
  input  logic              clr_en,
  input  logic [NUM_EV-1:0] clr_bits,
  input  logic              hold_fault,
  input  logic [NUM_EV-1:0] ev_en,
  input  logic              global_en,
  output logic [NUM_EV-1:0] sts_q,
  output logic              irq
);
  logic [NUM_EV-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
    if (hold_fault) clr_eff[EV_FAULT] = 1'b0;
  end

  generate
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
      // a new event in the clearing cycle wins over the clear
      always_ff @(posedge clk) begin
        if (!rst_n)         sts_q[i] <= 1'b0;
        else if (set_ev[i]) sts_q[i] <= 1'b1;
        else if (clr_eff[i]) sts_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign irq = global_en && |(sts_q & ev_en);
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int          CMD_DELAY  = 4,
  parameter int          PWR_DELAY  = 3,
  parameter int          DEBOUNCE   = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  LINK_SPEED = 4'd1,
  parameter logic [5:0]  LINK_WIDTH = 6'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              btn_in,
  input  logic              fault_in,
  input  logic              latch_in,
  input  logic              present_in,
  output logic [1:0]        attn_led,
  output logic [1:0]        pwr_led,
  output logic              slot_power,
  output logic              irq
);
  localparam int NUM_IN = 4;
  localparam logic [DATA_W-1:0] LCAP_WORD = DATA_W'({LINK_WIDTH, LINK_SPEED});

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              btn_s, fault_s, latch_s, pres_s;
  logic              btn_deb, btn_prev, latch_prev, pres_prev;
  logic              ctrl_wr, stat_wr, cmd_done;
  logic [DATA_W-1:0] ctrl_q;
  logic [NUM_EV-1:0] set_ev, sts_q;
  logic [DATA_W-1:0] stat_word;
  reg_sel_e          sel;

  assign raw_in = {present_in, latch_in, fault_in, btn_in};

  hp_in_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );
  assign {pres_s, latch_s, fault_s, btn_s} = sync_in;

  hp_debounce #(.CYCLES(DEBOUNCE)) u_deb (
    .clk(clk), .rst_n(rst_n), .d(btn_s), .q(btn_deb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_prev   <= 1'b0;
      latch_prev <= 1'b0;
      pres_prev  <= 1'b0;
    end else begin
      btn_prev   <= btn_deb;
      latch_prev <= latch_s;
      pres_prev  <= pres_s;
    end
  end

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign stat_wr = bus_wr && (sel == SEL_STAT);

  hp_ctrl_reg #(.CMD_DELAY(CMD_DELAY), .PWR_DELAY(PWR_DELAY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .cmd_done(cmd_done), .slot_power(slot_power)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[EV_BTN]   = btn_deb && !btn_prev;
    set_ev[EV_FAULT] = fault_s;
    set_ev[EV_LATCH] = latch_s ^ latch_prev;
    set_ev[EV_PRES]  = pres_s ^ pres_prev;
    set_ev[EV_CMD]   = cmd_done;
  end

  hp_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev),
    .clr_en(stat_wr), .clr_bits(bus_wdata[NUM_EV-1:0]),
    .hold_fault(!slot_power),
    .ev_en(ctrl_q[NUM_EV-1:0]), .global_en(ctrl_q[C_GLOBAL_EN]),
    .sts_q(sts_q), .irq(irq)
  );

  assign attn_led  = ctrl_q[C_ATTN_LO +: 2];
  assign pwr_led   = ctrl_q[C_PIND_LO +: 2];
  assign stat_word = DATA_W'({pres_s, latch_s, sts_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (sel)
          SEL_CTRL: bus_rdata <= ctrl_q;
          SEL_STAT: bus_rdata <= stat_word;
          SEL_LCAP: bus_rdata <= LCAP_WORD;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk
  import hp_slot_pkg::*;
#(
  parameter int CMD_DELAY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              irq,
  input logic              slot_power,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [NUM_EV-1:0] sts_q
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == SEL_CTRL);

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == ($past(bus_wdata) & CTRL_MASK));

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  generate
    if (CMD_DELAY > 1) begin : g_cmd
      assert_cmd_not_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[EV_CMD]) |-> !$past(ctrl_wr));
    end
  endgenerate

  assert_fault_held_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_power && sts_q[EV_FAULT]) |=> sts_q[EV_FAULT]);

  assert_irq_falls_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));

  assert_power_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_power) |-> slot_power == !$past(ctrl_q[C_PWR_OFF]));
endmodule

bind hp_slot_regs hp_slot_regs_chk #(.CMD_DELAY(CMD_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .irq(irq), .slot_power(slot_power), .ctrl_q(ctrl_q), .sts_q(sts_q)
);

// File: tb/test_hp_slot_regs.sv
`timescale 1ns/1ps
module test_hp_slot_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        btn_in = 1'b0, fault_in = 1'b0, latch_in = 1'b0, present_in = 1'b0;
  logic [1:0]  attn_led, pwr_led;
  logic        slot_power, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hp_slot_regs i_hp_slot_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .btn_in(btn_in), .fault_in(fault_in),
    .latch_in(latch_in), .present_in(present_in), .attn_led(attn_led),
    .pwr_led(pwr_led), .slot_power(slot_power), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(2'd0, v); chk("R1 ctrl reset", v, 16'h07C0);
    rd_reg(2'd1, v); chk("R1 status reset", v, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 slot_power", {15'b0, slot_power}, 16'h0);
    chk("R1 attn_led", {14'b0, attn_led}, 16'h3);
    chk("R1 pwr_led", {14'b0, pwr_led}, 16'h3);
  endtask

  task automatic t_link_cap();
    logic [15:0] v;
    rd_reg(2'd2, v); chk("R3 link cap", v, 16'h0011);
    chk("R3 rvalid", {15'b0, bus_rvalid}, 16'h1);
    wr_reg(2'd2, 16'hFFFF);
    rd_reg(2'd2, v); chk("R3 link cap after write", v, 16'h0011);
    rd_reg(2'd3, v); chk("R3 unused address", v, 16'h0000);
  endtask

  task automatic t_ctrl_write();
    logic [15:0] v;
    wr_reg(2'd0, 16'hF680);
    chk("R2 attn blink", {14'b0, attn_led}, 16'h2);
    chk("R2 pwr blink", {14'b0, pwr_led}, 16'h2);
    rd_reg(2'd0, v); chk("R2 ctrl mask", v, 16'h0680);
    wr_reg(2'd0, 16'h0540);
    chk("R2 attn on", {14'b0, attn_led}, 16'h1);
    chk("R2 pwr on", {14'b0, pwr_led}, 16'h1);
  endtask

  task automatic t_cmd_timing();
    wr_reg(2'd0, 16'h0430);
    idle(10);
    wr_reg(2'd1, 16'h001F);
    chk("R4 irq cleared", {15'b0, irq}, 16'h0);
    wr_reg(2'd0, 16'h0430);
    for (int k = 1; k <= CMDD; k++) begin
      @(negedge clk);
      chk("R4 cmd complete timing", {15'b0, irq}, (k == CMDD) ? 16'h1 : 16'h0);
    end
  endtask

  task automatic t_cmd_restart();
    wr_reg(2'd1, 16'h001F);
    wr_reg(2'd0, 16'h0430);
    idle(2);
    wr_reg(2'd0, 16'h0430);
    for (int k = 1; k <= CMDD; k++) begin
      @(negedge clk);
      chk("R4 restart timing", {15'b0, irq}, (k == CMDD) ? 16'h1 : 16'h0);
    end
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    idle(6);
    wr_reg(2'd1, 16'h0000);
    rd_reg(2'd1, v); chk("R5 write 0 keeps", v, 16'h0010);
    wr_reg(2'd1, 16'h001F);
    rd_reg(2'd1, v); chk("R5 write 1 clears", v, 16'h0000);
  endtask

  task automatic t_latch_pres();
    logic [15:0] v;
    latch_in = 1'b1; idle(6);
    rd_reg(2'd1, v); chk("R7 latch rise", v, 16'h0024);
    wr_reg(2'd1, 16'h0004);
    rd_reg(2'd1, v); chk("R7 latch cleared", v, 16'h0020);
    latch_in = 1'b0; idle(6);
    rd_reg(2'd1, v); chk("R7 latch fall", v, 16'h0004);
    wr_reg(2'd1, 16'h001F);
    present_in = 1'b1; idle(6);
    rd_reg(2'd1, v); chk("R7 presence rise", v, 16'h0048);
    wr_reg(2'd1, 16'h0008);
    present_in = 1'b0; idle(6);
    rd_reg(2'd1, v); chk("R7 presence fall", v, 16'h0008);
    wr_reg(2'd1, 16'h001F);
  endtask

  task automatic t_button();
    logic [15:0] v;
    btn_in = 1'b1; idle(2); btn_in = 1'b0; idle(10);
    rd_reg(2'd1, v); chk("R8 short pulse ignored", v, 16'h0000);
    btn_in = 1'b1; idle(10);
    rd_reg(2'd1, v); chk("R8 press", v, 16'h0001);
    wr_reg(2'd1, 16'h0001);
    btn_in = 1'b0; idle(10);
    rd_reg(2'd1, v); chk("R8 release sets nothing", v, 16'h0000);
  endtask

  task automatic t_irq();
    wr_reg(2'd0, 16'h0424);
    idle(10);
    wr_reg(2'd1, 16'h001F);
    chk("R9 idle irq", {15'b0, irq}, 16'h0);
    latch_in = 1'b1; idle(6);
    chk("R9 enabled event", {15'b0, irq}, 16'h1);
    wr_reg(2'd0, 16'h0404);
    chk("R9 global off", {15'b0, irq}, 16'h0);
    wr_reg(2'd0, 16'h0424);
    chk("R9 global on", {15'b0, irq}, 16'h1);
    wr_reg(2'd1, 16'h0004);
    chk("R9 drop after clear", {15'b0, irq}, 16'h0);
    latch_in = 1'b0; idle(6);
    wr_reg(2'd0, 16'h07C0);
    idle(8);
    wr_reg(2'd1, 16'h001F);
  endtask

  task automatic t_fault_power();
    logic [15:0] v;
    fault_in = 1'b1; idle(4); fault_in = 1'b0; idle(4);
    rd_reg(2'd1, v); chk("R6 fault latched", v, 16'h0002);
    wr_reg(2'd1, 16'h0002);
    rd_reg(2'd1, v); chk("R6 clear ignored unpowered", v, 16'h0002);
    wr_reg(2'd0, 16'h03C0);
    for (int k = 1; k <= PWRD; k++) begin
      @(negedge clk);
      chk("R10 power on delay", {15'b0, slot_power}, (k == PWRD) ? 16'h1 : 16'h0);
    end
    idle(4);
    wr_reg(2'd1, 16'h001F);
    rd_reg(2'd1, v); chk("R6 clear when powered", v, 16'h0000);
    fault_in = 1'b1; idle(4);
    wr_reg(2'd1, 16'h0002);
    rd_reg(2'd1, v); chk("R6 clear loses to active fault", v, 16'h0002);
    fault_in = 1'b0; idle(4);
    wr_reg(2'd1, 16'h0002);
    rd_reg(2'd1, v); chk("R6 clear after fault gone", v, 16'h0000);
    wr_reg(2'd0, 16'h07C0);
    for (int k = 1; k <= PWRD; k++) begin
      @(negedge clk);
      chk("R10 power off delay", {15'b0, slot_power}, (k == PWRD) ? 16'h0 : 16'h1);
    end
  endtask

  localparam int CMDD = 4;
  localparam int PWRD = 3;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_link_cap();
    t_ctrl_write();
    t_cmd_timing();
    t_cmd_restart();
    t_w1c();
    t_latch_pres();
    t_button();
    t_irq();
    t_fault_power();
    idle(2);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule